// File: doc/BRIEF.md
# Multiplexed 8-bit Host Mailbox Port

This block lets an external 8-bit host talk to an on-chip processor through a small mailbox. The host uses a single shared 8-bit bus for both address and data. A high pulse on `hale` loads the register address from that bus. After that, an active-low `hwr_n` or `hrd_n` strobe moves one byte, and only while the active-low select `hsel_n` is low. The pad ring combines the split bus pins (`hbus_in`, `hbus_out`, `hbus_oe`) into the bidirectional bus.

There are eight locations. Locations 0 to 5 are data mailboxes, and each one has a host-to-core half and a core-to-host half. Location 6 reports which host-to-core mailboxes hold unread data. Location 7 reports which core-to-host mailboxes hold unread data. The core side has a plain single-cycle register port, word width `REG_W`, plus the two flag vectors. The host strobes are synchronised into `clk`. A write takes effect when `hwr_n` rises. The host sees only the low byte of each register.

Top module: `hostport_mux8`

## Requirements
- R1: After reset, every full flag is 0, `hbus_oe` is 0 and every data mailbox reads 0 from both sides.
- R2: While `hale` is high, the port loads the location address from `hbus_in[2:0]`. It keeps that address through the following data phase, whatever the bus then carries.
- R3: A host write stores the byte into the host-to-core half of the addressed data location, zero-extended to `REG_W`. The core reads it back at `dsp_addr` on `dsp_rdata` in the same cycle that `dsp_rd` is high.
- R4: A write strobe given while `hsel_n` is high changes no register and no flag.
- R5: `hbus_oe` is 1 exactly while `hsel_n` and `hrd_n` are both low.
- R6: A host write to data location i (0..5) sets `h2d_full[i]`. A core read of location i clears it.
- R7: A core write (`dsp_wr`) to data location i sets `d2h_full[i]`. A completed host read of location i, ended by `hrd_n` rising while selected, clears it.
- R8: Location 6 reads as `h2d_full` and location 7 reads as `d2h_full`, with bit i standing for location i and the upper bits zero, from both sides. Writes to locations 6 and 7 from either side are ignored.
- R9: A host read of data location i returns only the low 8 bits of the core-to-host word.
- R10: The byte stored by a host write is the value the bus held last before `hwr_n` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hale | input | 1 | Host address latch strobe, active high |
| hsel_n | input | 1 | Host port select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hbus_in | input | 8 | Shared bus value seen at the pad |
| hbus_out | output | 8 | Read data toward the pad |
| hbus_oe | output | 1 | Pad output enable for the shared bus |
| dsp_addr | input | 3 | Core-side location address |
| dsp_wr | input | 1 | Core-side write enable |
| dsp_rd | input | 1 | Core-side read (clears flag) |
| dsp_wdata | input | 16 | Core-side write data |
| dsp_rdata | output | 16 | Core-side read data |
| h2d_full | output | 6 | Unread host-to-core mailboxes |
| d2h_full | output | 6 | Unread core-to-host mailboxes |

## Verification
The assertions assume the host never has a read and a write completing in the same cycle. They also assume the host holds the bus steady for a few clock cycles after each strobe edge, and keeps the select low until the synchronised strobe edge has been seen. The bench meets these assumptions: every host phase lasts several clock periods, the bus and the select are released only four cycles after the strobe, and core accesses are never issued while a host transfer is finishing.

// File: rtl/hip_pkg.sv
package hip_pkg;
  localparam int HIP_HOST_W = 8;
  localparam int HIP_NLOC   = 8;
  localparam int HIP_REG_W  = 16;
  localparam int HIP_NDATA  = HIP_NLOC - 2;
  localparam int HIP_AW     = $clog2(HIP_NLOC);
endpackage

// File: rtl/hip_sync.sv
module hip_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hip_hostctl.sv
module hip_hostctl #(
  parameter int AW = 3,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic          sel_s_n,
  input  logic          rd_s_n,
  input  logic          wr_s_n,
  input  logic [HW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [HW-1:0] wdat_q,
  output logic          wr_pulse,
  output logic          rd_pulse
);
  logic [AW-1:0] addr_d;
  logic [HW-1:0] wdat_d;
  logic          wr_prev_q, rd_prev_q;

  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (ale_s)   addr_d = bus_in[AW-1:0];
    if (!wr_s_n) wdat_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdat_q    <= '0;
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      addr_q    <= addr_d;
      wdat_q    <= wdat_d;
      wr_prev_q <= wr_s_n;
      rd_prev_q <= rd_s_n;
    end
  end

  assign wr_pulse = wr_s_n & ~wr_prev_q & ~sel_s_n;
  assign rd_pulse = rd_s_n & ~rd_prev_q & ~sel_s_n;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(addr_q));
endmodule

// File: rtl/hip_regbank.sv
module hip_regbank #(
  parameter int AW    = 3,
  parameter int HW    = 8,
  parameter int NDATA = 6,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    h_addr,
  input  logic [HW-1:0]    h_wdat,
  input  logic             h_wr,
  input  logic             h_rd_done,
  input  logic [AW-1:0]    d_addr,
  input  logic             d_wr,
  input  logic             d_rd,
  input  logic [REG_W-1:0] d_wdata,
  output logic [HW-1:0]    h_rdata,
  output logic [REG_W-1:0] d_rdata,
  output logic [NDATA-1:0] h2d_full,
  output logic [NDATA-1:0] d2h_full
);
  localparam logic [AW-1:0] ST_H2D = AW'(NDATA);
  localparam logic [AW-1:0] ST_D2H = AW'(NDATA + 1);

  logic [REG_W-1:0] h2d_q [NDATA];
  logic [REG_W-1:0] d2h_q [NDATA];
  logic [REG_W-1:0] h2d_d [NDATA];
  logic [REG_W-1:0] d2h_d [NDATA];
  logic [NDATA-1:0] h2d_full_q, h2d_full_d, d2h_full_q, d2h_full_d;
  logic [NDATA-1:0] h_hit, d_hit;

  for (genvar i = 0; i < NDATA; i++) begin : g_hit
    assign h_hit[i] = (h_addr == AW'(i));
    assign d_hit[i] = (d_addr == AW'(i));
  end

  // Next state; a new write wins over a same-cycle clearing read.
  always_comb begin
    for (int i = 0; i < NDATA; i++) begin
      h2d_d[i]      = h2d_q[i];
      d2h_d[i]      = d2h_q[i];
      h2d_full_d[i] = h2d_full_q[i];
      d2h_full_d[i] = d2h_full_q[i];
      if (d_rd && d_hit[i])      h2d_full_d[i] = 1'b0;
      if (h_rd_done && h_hit[i]) d2h_full_d[i] = 1'b0;
      if (h_wr && h_hit[i]) begin
        h2d_d[i]      = REG_W'(h_wdat);
        h2d_full_d[i] = 1'b1;
      end
      if (d_wr && d_hit[i]) begin
        d2h_d[i]      = d_wdata;
        d2h_full_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDATA; i++) begin
        h2d_q[i] <= '0;
        d2h_q[i] <= '0;
      end
      h2d_full_q <= '0;
      d2h_full_q <= '0;
    end else begin
      for (int i = 0; i < NDATA; i++) begin
        h2d_q[i] <= h2d_d[i];
        d2h_q[i] <= d2h_d[i];
      end
      h2d_full_q <= h2d_full_d;
      d2h_full_q <= d2h_full_d;
    end
  end

  always_comb begin
    h_rdata = '0;
    d_rdata = '0;
    for (int i = 0; i < NDATA; i++) begin
      if (h_hit[i]) h_rdata = d2h_q[i][HW-1:0];
      if (d_hit[i]) d_rdata = h2d_q[i];
    end
    if (h_addr == ST_H2D) h_rdata = HW'(h2d_full_q);
    if (h_addr == ST_D2H) h_rdata = HW'(d2h_full_q);
    if (d_addr == ST_H2D) d_rdata = REG_W'(h2d_full_q);
    if (d_addr == ST_D2H) d_rdata = REG_W'(d2h_full_q);
  end

  assign h2d_full = h2d_full_q;
  assign d2h_full = d2h_full_q;

  // R6
  h2d_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && (h_hit != '0)) |=> ((h2d_full_q & $past(h_hit)) == $past(h_hit)));
  // R6
  h2d_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && (d_hit != '0) && !(h_wr && (h_hit == d_hit)))
      |=> ((h2d_full_q & $past(d_hit)) == '0));
  // R7
  d2h_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && (d_hit != '0)) |=> ((d2h_full_q & $past(d_hit)) == $past(d_hit)));
  // R7
  d2h_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_done && (h_hit != '0) && !(d_wr && (d_hit == h_hit)))
      |=> ((d2h_full_q & $past(h_hit)) == '0));
  // R8
  st_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && (h_hit == '0) && !d_rd) |=> $stable(h2d_full_q));
endmodule

// File: rtl/hostport_mux8.sv
module hostport_mux8
  import hip_pkg::*;
#(
  parameter int HOST_W = HIP_HOST_W,
  parameter int AW     = HIP_AW,
  parameter int NDATA  = HIP_NDATA,
  parameter int REG_W  = HIP_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hale,
  input  logic              hsel_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic [HOST_W-1:0] hbus_in,
  output logic [HOST_W-1:0] hbus_out,
  output logic              hbus_oe,
  input  logic [AW-1:0]     dsp_addr,
  input  logic              dsp_wr,
  input  logic              dsp_rd,
  input  logic [REG_W-1:0]  dsp_wdata,
  output logic [REG_W-1:0]  dsp_rdata,
  output logic [NDATA-1:0]  h2d_full,
  output logic [NDATA-1:0]  d2h_full
);
  logic [3:0]        strb_s;
  logic [AW-1:0]     h_addr;
  logic [HOST_W-1:0] h_wdat;
  logic              h_wr, h_rd_done;

  hip_sync #(.W(4), .RST_VAL(4'b0111)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hale, hsel_n, hrd_n, hwr_n}),
    .q(strb_s)
  );

  hip_hostctl #(.AW(AW), .HW(HOST_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ale_s(strb_s[3]), .sel_s_n(strb_s[2]), .rd_s_n(strb_s[1]), .wr_s_n(strb_s[0]),
    .bus_in(hbus_in),
    .addr_q(h_addr), .wdat_q(h_wdat),
    .wr_pulse(h_wr), .rd_pulse(h_rd_done)
  );

  hip_regbank #(.AW(AW), .HW(HOST_W), .NDATA(NDATA), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wdat(h_wdat), .h_wr(h_wr), .h_rd_done(h_rd_done),
    .d_addr(dsp_addr), .d_wr(dsp_wr), .d_rd(dsp_rd), .d_wdata(dsp_wdata),
    .h_rdata(hbus_out), .d_rdata(dsp_rdata),
    .h2d_full(h2d_full), .d2h_full(d2h_full)
  );

  assign hbus_oe = ~hsel_n & ~hrd_n;

  // R4
  no_wr_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |-> !strb_s[2]);
  // Host never completes a read and a write together (input assumption)
  one_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_wr && h_rd_done));
endmodule

// File: tb/tb_hostport_mux8.sv
module tb_hostport_mux8;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hale, hsel_n, hrd_n, hwr_n;
  logic [7:0]  hbus_in, hbus_out;
  logic        hbus_oe;
  logic [2:0]  dsp_addr;
  logic        dsp_wr, dsp_rd;
  logic [15:0] dsp_wdata, dsp_rdata;
  logic [5:0]  h2d_full, d2h_full;
  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  hostport_mux8 dut (
    .clk(clk), .rst_n(rst_n), .hale(hale), .hsel_n(hsel_n), .hrd_n(hrd_n),
    .hwr_n(hwr_n), .hbus_in(hbus_in), .hbus_out(hbus_out), .hbus_oe(hbus_oe),
    .dsp_addr(dsp_addr), .dsp_wr(dsp_wr), .dsp_rd(dsp_rd), .dsp_wdata(dsp_wdata),
    .dsp_rdata(dsp_rdata), .h2d_full(h2d_full), .d2h_full(d2h_full)
  );

  // {req[3:0], op[1:0], addr[2:0], data[15:0], expect[15:0]}
  // op: 0 host write, 1 host read, 2 core write, 3 core read
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {4'd9, 2'd2, 3'd0, 16'hABCD, 16'h0000},
    {4'd9, 2'd1, 3'd0, 16'h0000, 16'h00CD},  // R9 low byte only
    {4'd7, 2'd1, 3'd7, 16'h0000, 16'h0000},  // R7 cleared by host read
    {4'd3, 2'd0, 3'd2, 16'h005A, 16'h0000},
    {4'd6, 2'd1, 3'd6, 16'h0000, 16'h0004},  // R6 flag 2 set
    {4'd3, 2'd3, 3'd2, 16'h0000, 16'h005A},  // R3 zero-extended
    {4'd6, 2'd1, 3'd6, 16'h0000, 16'h0000},  // R6 cleared by core read
    {4'd3, 2'd0, 3'd5, 16'h00FF, 16'h0000},
    {4'd8, 2'd3, 3'd6, 16'h0000, 16'h0020},  // R8 status from core
    {4'd7, 2'd2, 3'd3, 16'h1234, 16'h0000},
    {4'd8, 2'd3, 3'd7, 16'h0000, 16'h0008},  // R8
    {4'd9, 2'd1, 3'd3, 16'h0000, 16'h0034},  // R9
    {4'd7, 2'd3, 3'd7, 16'h0000, 16'h0000},  // R7
    {4'd8, 2'd0, 3'd6, 16'h0077, 16'h0000},  // R8 write to status
    {4'd8, 2'd3, 3'd6, 16'h0000, 16'h0020},  // R8 status unchanged
    {4'd3, 2'd3, 3'd5, 16'h0000, 16'h00FF},  // R3
    {4'd6, 2'd3, 3'd6, 16'h0000, 16'h0000}   // R6
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_latch(input logic [2:0] a);
    @(negedge clk);
    hbus_in = {5'b0, a};
    hale = 1'b1;
    repeat (3) @(negedge clk);
    hale = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
    host_latch(a);
    hsel_n = ~sel;
    hbus_in = d;
    hwr_n = 1'b0;
    repeat (4) @(negedge clk);
    hwr_n = 1'b1;
    repeat (4) @(negedge clk);
    hsel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d, output logic oe);
    host_latch(a);
    hbus_in = 8'hE5;
    hsel_n = 1'b0;
    hrd_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    d = hbus_out;
    oe = hbus_oe;
    hrd_n = 1'b1;
    repeat (4) @(negedge clk);
    hsel_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic core_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    dsp_addr = a;
    dsp_wdata = d;
    dsp_wr = 1'b1;
    @(negedge clk);
    dsp_wr = 1'b0;
  endtask

  task automatic core_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    dsp_addr = a;
    dsp_rd = 1'b1;
    #1;
    d = dsp_rdata;
    @(negedge clk);
    dsp_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0]  hd;
    logic        oe;
    logic [15:0] cd;
    rst_n = 1'b0; hale = 1'b0; hsel_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
    hbus_in = '0; dsp_addr = '0; dsp_wr = 1'b0; dsp_rd = 1'b0; dsp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, {10'b0, h2d_full}, 16'h0);
    check(1, {10'b0, d2h_full}, 16'h0);
    check(1, {15'b0, hbus_oe}, 16'h0);
    core_read(3'd1, cd);
    check(1, cd, 16'h0);
    host_read(3'd4, hd, oe);
    check(1, {8'b0, hd}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [2:0]  a;
      logic [15:0] d, e;
      {rq, op, a, d, e} = VEC[i];
      case (op)
        2'd0: host_write(a, d[7:0], 1'b1);
        2'd1: begin
          host_read(a, hd, oe);
          check(rq, {8'b0, hd}, e);
          check(5, {15'b0, oe}, 16'h1);  // R5 enabled during selected read
        end
        2'd2: core_write(a, d);
        default: begin
          core_read(a, cd);
          check(rq, cd, e);
        end
      endcase
    end

    // R2 and R10: address held while data changes; last bus value stored
    host_latch(3'd4);
    hsel_n = 1'b0;
    hbus_in = 8'h11;
    hwr_n = 1'b0;
    repeat (4) @(negedge clk);
    hbus_in = 8'h03;
    repeat (4) @(negedge clk);
    hwr_n = 1'b1;
    repeat (4) @(negedge clk);
    hsel_n = 1'b1;
    repeat (2) @(negedge clk);
    core_read(3'd3, cd);
    check(2, cd, 16'h0);
    core_read(3'd4, cd);
    check(10, cd, 16'h0003);

    // R4 write while deselected is ignored
    host_write(3'd1, 8'h99, 1'b0);
    core_read(3'd6, cd);
    check(4, cd, 16'h0);
    core_read(3'd1, cd);
    check(4, cd, 16'h0);

    // R5 no drive when read strobe without select, or select without read
    @(negedge clk);
    hrd_n = 1'b0;
    #1;
    check(5, {15'b0, hbus_oe}, 16'h0);
    hrd_n = 1'b1;
    hsel_n = 1'b0;
    #1;
    check(5, {15'b0, hbus_oe}, 16'h0);
    hsel_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule